// File: doc/BRIEF.md
# Not-Recently-Used Victim Frame Selector

This block picks which resident page frame should be given up when a new page must be brought in. For each of its frames it keeps two bits of history: a use bit, set by any access, and a dirty bit, set by a write. The two bits together place each frame in one of four classes. A frame that is neither used nor dirty is the cheapest to give up. A frame that is both used and dirty costs the most.

Access and load events enter as plain strobes with a frame index, and a clear-use strobe can arrive every cycle. None of these inputs has back-pressure: the block takes every event in the cycle it is presented. A one-cycle select request produces, one cycle later, a registered result with a one-cycle valid pulse. The result gives the chosen frame, its class and a flag saying that the frame's contents must be saved before the frame is reused. The result stays on the outputs until the next request.

The candidate frames form the lowest class that has any members. Among them, the pick starts at a pseudo-random index taken from a free-running 16-bit LFSR and scans upward, wrapping, to the first member.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset every frame has both bits clear, so all frames are in class 0. vic_valid, vic_frame, vic_class and vic_dirty are all zero.
- R2: An access strobe sets the use bit of its frame. When acc_write is 1 it also sets the dirty bit. A read leaves the dirty bit unchanged.
- R3: A load strobe sets the use bit and clears the dirty bit of its frame. It takes precedence over an access to the same frame in the same cycle.
- R4: A clear-use strobe clears every use bit and leaves every dirty bit as it was. A frame accessed or loaded in the same cycle keeps its use bit set.
- R5: The class of a frame is the 2-bit value {use, dirty}: 0 is unused and clean, 1 is unused and dirty, 2 is used and clean, 3 is used and dirty.
- R6: When sel_req is high at a clock edge, vic_valid is high for exactly the following cycle. vic_frame is then a member of the lowest-numbered class that has at least one member, and vic_class gives that class.
- R7: vic_dirty equals the dirty bit of the chosen frame.
- R8: Within the winning class, the scan starts at the low bits of a free-running LFSR and moves upward with wrap-around. With all 16 frames in one class, repeated requests return more than one distinct frame.
- R9: vic_frame, vic_class and vic_dirty keep their values until the next request, whatever other events occur.
- R10: A request uses the frame state from before any access, load or clear presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access event strobe |
| acc_frame | input | 4 | Frame index of the access |
| acc_write | input | 1 | Access is a write |
| load_valid | input | 1 | Page-load event strobe |
| load_frame | input | 4 | Frame index being loaded |
| clear_ref | input | 1 | Clear all use bits |
| sel_req | input | 1 | Select request |
| vic_valid | output | 1 | One-cycle pulse: new result |
| vic_frame | output | 4 | Chosen frame |
| vic_class | output | 2 | Class of the chosen frame |
| vic_dirty | output | 1 | Chosen frame must be saved before reuse |

## Verification
The situations hardest to reach from the ports are the collisions inside a single cycle. These are a request arriving together with a write to the only clean frame, a clear arriving together with an access, and a class that holds exactly one member among fifteen frames of a costlier class. The stimulus builds these states deliberately. It first writes every frame but one, or loads and clears everything. It then presents the colliding strobes in the same cycle. A reference model takes a snapshot of the bits at each request, so that every result is judged against the state before that cycle's events. The random spread is judged by collecting the distinct frames returned over a run of requests with all frames equal.

// File: rtl/nru_pkg.sv
package nru_pkg;
  typedef enum logic [1:0] {
    CLS_IDLE_CLEAN = 2'd0,
    CLS_IDLE_DIRTY = 2'd1,
    CLS_USED_CLEAN = 2'd2,
    CLS_USED_DIRTY = 2'd3
  } nru_class_e;

  localparam int NRU_CLASSES = 4;
endpackage

// File: rtl/nru_lfsr.sv
module nru_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] state
);
  logic fb;
  // taps 16,14,13,11
  assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[14:0], fb};
  end
endmodule

// File: rtl/nru_bits.sv
module nru_bits #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_frame,
  input  logic          acc_write,
  input  logic          load_valid,
  input  logic [IW-1:0] load_frame,
  input  logic          clear_ref,
  output logic [N-1:0]  use_bits,
  output logic [N-1:0]  dirty_bits
);
  for (genvar g = 0; g < N; g++) begin : g_frame
    logic hit_acc, hit_ld;
    assign hit_acc = acc_valid  && (acc_frame  == IW'(g));
    assign hit_ld  = load_valid && (load_frame == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        use_bits[g]   <= 1'b0;
        dirty_bits[g] <= 1'b0;
      end else if (hit_ld) begin
        use_bits[g]   <= 1'b1;
        dirty_bits[g] <= 1'b0;
      end else begin
        if (hit_acc)        use_bits[g] <= 1'b1;
        else if (clear_ref) use_bits[g] <= 1'b0;
        if (hit_acc && acc_write) dirty_bits[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nru_pick.sv
module nru_pick
  import nru_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  use_bits,
  input  logic [N-1:0]  dirty_bits,
  input  logic [IW-1:0] start,
  output logic [IW-1:0] pick_frame,
  output nru_class_e    pick_class
);
  logic [NRU_CLASSES-1:0][N-1:0] members;
  logic [N-1:0]                  cand;

  for (genvar k = 0; k < NRU_CLASSES; k++) begin : g_cls
    for (genvar f = 0; f < N; f++) begin : g_mem
      assign members[k][f] = ({use_bits[f], dirty_bits[f]} == 2'(k));
    end
  end

  always_comb begin
    pick_class = CLS_USED_DIRTY;
    cand       = members[3];
    for (int k = NRU_CLASSES - 2; k >= 0; k--) begin
      if (|members[k]) begin
        pick_class = nru_class_e'(2'(k));
        cand       = members[k];
      end
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    pick_frame = start;
    for (int j = 0; j < N; j++) begin
      int t;
      t = int'(start) + j;
      if (t >= N) t = t - N;
      if (!found && cand[t]) begin
        found      = 1'b1;
        pick_frame = IW'(t);
      end
    end
  end
endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel
  import nru_pkg::*;
#(
  parameter int          N    = 16,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int         IW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_frame,
  input  logic          acc_write,
  input  logic          load_valid,
  input  logic [IW-1:0] load_frame,
  input  logic          clear_ref,
  input  logic          sel_req,
  output logic          vic_valid,
  output logic [IW-1:0] vic_frame,
  output logic [1:0]    vic_class,
  output logic          vic_dirty
);
  logic [N-1:0]  use_bits, dirty_bits;
  logic [15:0]   rnd;
  logic [IW-1:0] pick_frame;
  nru_class_e    pick_class;

  nru_bits #(.N(N), .IW(IW)) u_bits (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
    .load_valid(load_valid), .load_frame(load_frame), .clear_ref(clear_ref),
    .use_bits(use_bits), .dirty_bits(dirty_bits)
  );

  nru_lfsr #(.SEED(SEED)) u_lfsr (.clk(clk), .rst_n(rst_n), .state(rnd));

  nru_pick #(.N(N), .IW(IW)) u_pick (
    .use_bits(use_bits), .dirty_bits(dirty_bits), .start(rnd[IW-1:0]),
    .pick_frame(pick_frame), .pick_class(pick_class)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_valid <= 1'b0;
      vic_frame <= '0;
      vic_class <= 2'd0;
      vic_dirty <= 1'b0;
    end else begin
      vic_valid <= sel_req;
      if (sel_req) begin
        vic_frame <= pick_frame;
        vic_class <= pick_class;
        vic_dirty <= dirty_bits[pick_frame];
      end
    end
  end
endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [IW-1:0] acc_frame,
  input logic          acc_write,
  input logic          load_valid,
  input logic [IW-1:0] load_frame,
  input logic          clear_ref,
  input logic          sel_req,
  input logic          vic_valid,
  input logic [IW-1:0] vic_frame,
  input logic [1:0]    vic_class,
  input logic          vic_dirty,
  input logic [N-1:0]  use_bits,
  input logic [N-1:0]  dirty_bits
);
  logic [N-1:0] use_q, dirty_q;
  logic [1:0]   low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      use_q   <= '0;
      dirty_q <= '0;
    end else begin
      use_q   <= use_bits;
      dirty_q <= dirty_bits;
    end
  end

  always_comb begin
    if      (|(~use_q & ~dirty_q)) low_q = 2'd0;
    else if (|(~use_q &  dirty_q)) low_q = 2'd1;
    else if (|( use_q & ~dirty_q)) low_q = 2'd2;
    else                           low_q = 2'd3;
  end

  a_r2_access_sets_use: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> use_bits[$past(acc_frame)]);

  a_r2_write_sets_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !(load_valid && load_frame == acc_frame))
      |=> dirty_bits[$past(acc_frame)]);

  a_r3_load_cleans: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> (use_bits[$past(load_frame)] && !dirty_bits[$past(load_frame)]));

  a_r4_clear_use: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_ref && !acc_valid && !load_valid) |=> (use_bits == '0));

  a_r4_clear_keeps_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_ref && !acc_valid && !load_valid) |=> $stable(dirty_bits));

  a_r6_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req |=> vic_valid);

  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_req |=> !vic_valid);

  a_r6_lowest_class: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> (vic_class == low_q &&
                   {use_q[vic_frame], dirty_q[vic_frame]} == vic_class));

  a_r7_dirty_flag: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> (vic_dirty == dirty_q[vic_frame]));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_req |=> ($stable(vic_frame) && $stable(vic_class) && $stable(vic_dirty)));
endmodule

bind nru_victim_sel nru_victim_sel_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
  .load_valid(load_valid), .load_frame(load_frame), .clear_ref(clear_ref),
  .sel_req(sel_req), .vic_valid(vic_valid), .vic_frame(vic_frame),
  .vic_class(vic_class), .vic_dirty(vic_dirty),
  .use_bits(use_bits), .dirty_bits(dirty_bits)
);

// File: tb/test_nru_victim_sel.sv
module test_nru_victim_sel;
  localparam int N = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, acc_write = 1'b0, load_valid = 1'b0;
  logic       clear_ref = 1'b0, sel_req = 1'b0;
  logic [3:0] acc_frame = '0, load_frame = '0;
  logic       vic_valid, vic_dirty;
  logic [3:0] vic_frame;
  logic [1:0] vic_class;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit track_seen = 1'b0;
  logic [N-1:0] seen = '0;
  logic [N-1:0] mu = '0, md = '0;
  logic [2*N-1:0] expq[$];

  always #2 clk = ~clk;

  nru_victim_sel i_nru_victim_sel (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
    .load_valid(load_valid), .load_frame(load_frame), .clear_ref(clear_ref),
    .sel_req(sel_req), .vic_valid(vic_valid), .vic_frame(vic_frame),
    .vic_class(vic_class), .vic_dirty(vic_dirty)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus; model follows R2, R3, R4 and R10
  task automatic cyc(bit av, int af, bit aw, bit lv, int lf, bit cl, bit sr);
    acc_valid = av;  acc_frame = 4'(af);  acc_write = aw;
    load_valid = lv; load_frame = 4'(lf); clear_ref = cl;  sel_req = sr;
    if (sr) expq.push_back({mu, md});
    for (int f = 0; f < N; f++) begin
      if (lv && lf == f) begin
        mu[f] = 1'b1; md[f] = 1'b0;
      end else begin
        if (av && af == f) mu[f] = 1'b1;
        else if (cl)       mu[f] = 1'b0;
        if (av && aw && af == f) md[f] = 1'b1;
      end
    end
    @(negedge clk);
    acc_valid = 0; load_valid = 0; clear_ref = 0; sel_req = 0;
  endtask

  task automatic access(int f, bit w); cyc(1, f, w, 0, 0, 0, 0); endtask
  task automatic load(int f);          cyc(0, 0, 0, 1, f, 0, 0); endtask
  task automatic clear();              cyc(0, 0, 0, 0, 0, 1, 0); endtask
  task automatic select();             cyc(0, 0, 0, 0, 0, 0, 1); endtask

  // scoreboard monitor: R5, R6, R7
  always @(negedge clk) begin
    if (rst_n && vic_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R6 unexpected result", 1, 0);
      end else begin
        logic [2*N-1:0] e;
        logic [N-1:0] su, sd;
        int lowc, fc;
        e = expq.pop_front();
        su = e[2*N-1:N];
        sd = e[N-1:0];
        lowc = 3;
        for (int f = 0; f < N; f++)
          if (int'({su[f], sd[f]}) < lowc) lowc = int'({su[f], sd[f]});
        fc = int'({su[vic_frame], sd[vic_frame]});
        check(int'(vic_class) == lowc, "R6 class", int'(vic_class), lowc);
        check(fc == lowc, "R5 frame class", fc, lowc);
        check(vic_dirty == sd[vic_frame], "R7 dirty", int'(vic_dirty), int'(sd[vic_frame]));
        if (track_seen) seen[vic_frame] = 1'b1;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(vic_valid == 0 && vic_frame == 0 && vic_class == 0 && vic_dirty == 0,
          "R1 reset outputs", int'({vic_valid, vic_frame, vic_class, vic_dirty}), 0);
    select();                                   // R1: all class 0
    for (int f = 0; f < N; f++) load(f);        // R3: all class 2
    select();
    for (int f = 0; f < 4; f++) access(f, 0);   // R2 read
    access(5, 1);                               // R2 write -> class 3
    select();
    clear();                                    // R4: 5 to class 1
    select();
    for (int f = 0; f < N; f++) if (f != 9) access(f, 1);
    select();                                   // only 9 in class 0
    clear();
    access(9, 0);                               // 9 class 2, rest class 1
    select();                                   // R7 dirty victim
    cyc(1, 7, 0, 0, 0, 1, 0);                   // R4 clear with access
    select();
    access(9, 1);
    load(4);                                    // R3 clears dirty
    select();
    // R10: request together with write to the only clean frame
    load(2); clear();
    for (int f = 0; f < N; f++) if (f != 2) access(f, 1);
    cyc(1, 2, 1, 0, 0, 0, 1);
    select();
    // R3 precedence: load and write same frame same cycle
    cyc(1, 6, 1, 1, 6, 0, 0);
    select();
    // R8 spread over one class
    for (int f = 0; f < N; f++) load(f);
    clear();
    track_seen = 1'b1;
    for (int i = 0; i < 32; i++) select();
    @(negedge clk);
    track_seen = 1'b0;
    check($countones(seen) >= 2, "R8 distinct picks", $countones(seen), 2);
    // R9 hold under unrelated events
    begin
      logic [3:0] hf;
      logic [1:0] hc;
      logic       hd;
      bit         ok;
      hf = vic_frame; hc = vic_class; hd = vic_dirty; ok = 1'b1;
      access(hf, 1); clear(); load(hf); access(3, 1);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (vic_frame != hf || vic_class != hc || vic_dirty != hd || vic_valid) ok = 1'b0;
      end
      check(ok, "R9 hold", int'(vic_frame), int'(hf));
    end
    check(expq.size() == 0, "R6 pending results", expq.size(), 0);
    finish_run();
  end
endmodule